// File: doc/BRIEF.md
# Multi-priority request queue selector

This block holds pending memory requests, each tagged with a direction, a start address, a byte size, a target rank, a bank, a row and a priority level. Requests wait in one queue per priority level, kept in arrival order. All levels draw from one shared pool of slots, so a burst at one level can use the whole pool.

On a select strobe the block looks for the next request to send to the memory. It tries the highest level first and moves down. Within a level it takes the oldest entry whose rank is currently refresh-idle. The result comes back one cycle later and stays held. The held entry leaves its queue only when the issue input is raised.

A read that arrives while a queued write covers its whole byte range is flagged as served from that write. It is not queued. Row-hit reordering and command timing are outside this block.

Top module: `prq_selector`

## Requirements
- R1: After reset the occupancy is zero, no selection is held and no select result is reported.
- R2: An enqueue that is not a covered read is refused (`enq_full_o`=1, `enq_ok_o`=0) when the total occupancy across all levels plus one exceeds `CAP`. A refused request leaves the occupancy unchanged. The accept and refuse outputs are combinational in the enqueue cycle.
- R3: An accepted request is appended to the tail of the queue named by `enq_prio_i`. The occupancy rises by one at the next clock edge.
- R4: A selection scans levels from index `NPRIO-1` down to 0 and stops at the first level that has a candidate. A higher index means a higher priority.
- R5: Within a level, the candidate is the oldest entry whose rank bit is set. Bit r of `rank_idle_i` set means rank r is refresh-idle. The bits are sampled in the strobe cycle.
- R6: A level holding exactly one entry yields that entry only if its rank is idle. Otherwise the scan moves to lower levels.
- R7: If no level yields a candidate, the result reports `sel_valid_o`=0 and the occupancy is not changed.
- R8: Selecting does not remove an entry. A repeated strobe picks the same entry again. The occupancy falls by one at the edge where `issue_i` is high while a selection is held.
- R9: Removing an entry keeps the remaining entries of that level in arrival order. Later entries move down by one index.
- R10: A read (`enq_wr_i`=0) whose range [addr, addr+size) lies fully inside the range of a queued write raises `enq_covered_o`. Such a read is not queued, even when the pool is full. A read that only partly overlaps a queued write is not covered.
- R11: `issue_i` with no held selection has no effect. A strobe in a cycle where `issue_i` is high is ignored and produces no result.
- R12: The result of a strobe (`sel_done_o`, `sel_valid_o`, `sel_prio_o`, `sel_idx_o`, `sel_addr_o`) appears one clock edge after the strobe cycle. The held selection fields keep their values until the next accepted strobe or an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| enq_valid_i | input | 1 | Enqueue request |
| enq_wr_i | input | 1 | 1 for a write, 0 for a read |
| enq_addr_i | input | ADDR_W | Start address |
| enq_size_i | input | SIZE_W | Size in bytes |
| enq_rank_i | input | RANK_W | Target rank |
| enq_bank_i | input | BANK_W | Target bank |
| enq_row_i | input | ROW_W | Target row |
| enq_prio_i | input | $clog2(NPRIO) | Priority level; a higher value means a higher priority |
| enq_ok_o | output | 1 | The request is queued this cycle |
| enq_full_o | output | 1 | The request is refused for lack of room |
| enq_covered_o | output | 1 | The read is served by a queued write |
| rank_idle_i | input | 2**RANK_W | Refresh-idle flag for each rank |
| sel_strobe_i | input | 1 | Start a selection |
| issue_i | input | 1 | Remove the held selection from its queue |
| sel_done_o | output | 1 | One-cycle pulse: a selection result is ready |
| sel_valid_o | output | 1 | A selection is held |
| sel_prio_o | output | $clog2(NPRIO) | Level of the held entry |
| sel_idx_o | output | $clog2(CAP) | Position of the held entry within its level (0 is the oldest) |
| sel_addr_o | output | ADDR_W | Address of the held entry |
| occupancy_o | output | $clog2(NPRIO*CAP+1) | Total number of queued entries |

## Verification
The bench builds the block with the default four levels, a shared pool of six slots and four ranks. These values let one short run fill the pool to its limit. They also give two levels with several entries each, so rank masking can skip an old entry in one level while a lower level still has a candidate. A pool of six makes the full-pool refusal and the covered-read-at-full case easy to reach. Four rank bits let single-entry levels be skipped and mid-queue entries be chosen and removed, which exercises the compaction path.

// File: rtl/prq_pkg.sv
package prq_pkg;
  parameter int ADDR_W = 16;
  parameter int SIZE_W = 8;
  parameter int RANK_W = 2;
  parameter int BANK_W = 3;
  parameter int ROW_W  = 8;
  localparam int NRANK = 1 << RANK_W;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
  } prq_entry_t;
endpackage

// File: rtl/prq_level.sv
module prq_level
  import prq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                         clk,
  input  logic                         rst_b,
  input  logic                         push_i,
  input  prq_entry_t                   push_e_i,
  input  logic                         pop_i,
  input  logic [$clog2(DEPTH)-1:0]     pop_idx_i,
  input  logic [NRANK-1:0]             rank_idle_i,
  output prq_entry_t                   ent_o [DEPTH],
  output logic [DEPTH-1:0]             vld_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         cand_found_o,
  output logic [$clog2(DEPTH)-1:0]     cand_idx_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  prq_entry_t    ent_q [DEPTH];
  prq_entry_t    ent_d [DEPTH];
  logic [CW-1:0] count_q, count_d, base;

  // next state: compact on removal, then append at the tail
  always_comb begin
    for (int j = 0; j < DEPTH; j++) ent_d[j] = ent_q[j];
    base = count_q;
    if (pop_i) begin
      for (int j = 0; j < DEPTH-1; j++)
        if (IW'(j) >= pop_idx_i) ent_d[j] = ent_q[j+1];
      base = count_q - 1'b1;
    end
    count_d = base;
    if (push_i) begin
      for (int j = 0; j < DEPTH; j++)
        if (CW'(j) == base) ent_d[j] = push_e_i;
      count_d = base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    if (push_i || pop_i)
      for (int j = 0; j < DEPTH; j++) ent_q[j] <= ent_d[j];
  end

  // oldest entry whose rank is refresh-idle
  always_comb begin
    cand_found_o = 1'b0;
    cand_idx_o   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!cand_found_o && (CW'(i) < count_q) && rank_idle_i[ent_q[i].rank]) begin
        cand_found_o = 1'b1;
        cand_idx_o   = IW'(i);
      end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_o[i] = ent_q[i];
      vld_o[i] = CW'(i) < count_q;
    end
  end
  assign count_o = count_q;

  // R2
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_b)
    (push_i && !pop_i) |-> (count_q < CW'(DEPTH)));
  // R9
  pop_idx_chk: assert property (@(posedge clk) disable iff (!rst_b)
    pop_i |-> (CW'(pop_idx_i) < count_q));
endmodule

// File: rtl/prq_cover.sv
module prq_cover
  import prq_pkg::*;
#(
  parameter int N = 24
) (
  input  prq_entry_t          ent_i [N],
  input  logic [N-1:0]        wr_vld_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic                hit_o
);
  localparam int SW = ADDR_W + 1;

  logic [N-1:0] slot_hit;
  logic [SW-1:0] rd_end;
  assign rd_end = {1'b0, addr_i} + SW'(size_i);

  for (genvar s = 0; s < N; s++) begin : g_slot
    logic [SW-1:0] wr_end;
    assign wr_end = {1'b0, ent_i[s].addr} + SW'(ent_i[s].size);
    assign slot_hit[s] = wr_vld_i[s] && (ent_i[s].addr <= addr_i) && (rd_end <= wr_end);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/prq_selector.sv
module prq_selector
  import prq_pkg::*;
#(
  parameter int NPRIO = 4,
  parameter int CAP   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enq_valid_i,
  input  logic                           enq_wr_i,
  input  logic [ADDR_W-1:0]              enq_addr_i,
  input  logic [SIZE_W-1:0]              enq_size_i,
  input  logic [RANK_W-1:0]              enq_rank_i,
  input  logic [BANK_W-1:0]              enq_bank_i,
  input  logic [ROW_W-1:0]               enq_row_i,
  input  logic [$clog2(NPRIO)-1:0]       enq_prio_i,
  output logic                           enq_ok_o,
  output logic                           enq_full_o,
  output logic                           enq_covered_o,
  input  logic [NRANK-1:0]               rank_idle_i,
  input  logic                           sel_strobe_i,
  input  logic                           issue_i,
  output logic                           sel_done_o,
  output logic                           sel_valid_o,
  output logic [$clog2(NPRIO)-1:0]       sel_prio_o,
  output logic [$clog2(CAP)-1:0]         sel_idx_o,
  output logic [ADDR_W-1:0]              sel_addr_o,
  output logic [$clog2(NPRIO*CAP+1)-1:0] occupancy_o
);
  localparam int PIW  = $clog2(NPRIO);
  localparam int IW   = $clog2(CAP);
  localparam int CW   = $clog2(CAP+1);
  localparam int TW   = $clog2(NPRIO*CAP+1);
  localparam int NALL = NPRIO*CAP;

  // reset: asynchronous assertion, synchronized release
  logic [1:0] rst_sync_q;
  logic       rst_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_b = rst_sync_q[1];

  prq_entry_t        ent_w  [NPRIO][CAP];
  logic [CAP-1:0]    vld_w  [NPRIO];
  logic [CW-1:0]     cnt_w  [NPRIO];
  logic [NPRIO-1:0]  cand_found_w;
  logic [IW-1:0]     cand_idx_w [NPRIO];
  logic [NPRIO-1:0]  push_w, pop_w;
  prq_entry_t        new_e;

  logic            sel_valid_q, sel_valid_d, sel_done_q;
  logic [PIW-1:0]  sel_prio_q;
  logic [IW-1:0]   sel_idx_q;
  logic [ADDR_W-1:0] sel_addr_q;
  logic            do_issue, take;

  assign new_e = '{wr: enq_wr_i, addr: enq_addr_i, size: enq_size_i,
                   rank: enq_rank_i, bank: enq_bank_i, row: enq_row_i};
  assign do_issue = issue_i && sel_valid_q;
  assign take     = sel_strobe_i && !issue_i;

  for (genvar l = 0; l < NPRIO; l++) begin : g_lvl
    assign push_w[l] = enq_ok_o && (enq_prio_i == PIW'(l));
    assign pop_w[l]  = do_issue && (sel_prio_q == PIW'(l));
    prq_level #(.DEPTH(CAP)) u_lvl (
      .clk(clk), .rst_b(rst_b),
      .push_i(push_w[l]), .push_e_i(new_e),
      .pop_i(pop_w[l]), .pop_idx_i(sel_idx_q),
      .rank_idle_i(rank_idle_i),
      .ent_o(ent_w[l]), .vld_o(vld_w[l]), .count_o(cnt_w[l]),
      .cand_found_o(cand_found_w[l]), .cand_idx_o(cand_idx_w[l])
    );
  end

  // shared occupancy and admission
  logic [TW-1:0] occ;
  always_comb begin
    occ = '0;
    for (int l = 0; l < NPRIO; l++) occ = occ + TW'(cnt_w[l]);
  end
  assign occupancy_o = occ;

  prq_entry_t     flat_e [NALL];
  logic [NALL-1:0] flat_wv;
  logic            cover_hit;
  always_comb begin
    for (int l = 0; l < NPRIO; l++)
      for (int s = 0; s < CAP; s++) begin
        flat_e[l*CAP+s]  = ent_w[l][s];
        flat_wv[l*CAP+s] = vld_w[l][s] && ent_w[l][s].wr;
      end
  end

  prq_cover #(.N(NALL)) u_cover (
    .ent_i(flat_e), .wr_vld_i(flat_wv),
    .addr_i(enq_addr_i), .size_i(enq_size_i), .hit_o(cover_hit)
  );

  assign enq_covered_o = enq_valid_i && !enq_wr_i && cover_hit;
  assign enq_full_o    = enq_valid_i && !enq_covered_o && (occ >= TW'(CAP));
  assign enq_ok_o      = enq_valid_i && !enq_covered_o && !enq_full_o;

  // priority scan, highest level first
  logic            pick_found;
  logic [PIW-1:0]  pick_prio;
  logic [IW-1:0]   pick_idx;
  logic [ADDR_W-1:0] pick_addr;
  always_comb begin
    pick_found = 1'b0;
    pick_prio  = '0;
    pick_idx   = '0;
    pick_addr  = '0;
    for (int l = NPRIO-1; l >= 0; l--)
      if (!pick_found && cand_found_w[l]) begin
        pick_found = 1'b1;
        pick_prio  = PIW'(l);
        pick_idx   = cand_idx_w[l];
        pick_addr  = ent_w[l][cand_idx_w[l]].addr;
      end
  end

  always_comb begin
    sel_valid_d = sel_valid_q;
    if (take)          sel_valid_d = pick_found;
    else if (do_issue) sel_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      sel_valid_q <= 1'b0;
      sel_done_q  <= 1'b0;
    end else begin
      sel_valid_q <= sel_valid_d;
      sel_done_q  <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (take && pick_found) begin
      sel_prio_q <= pick_prio;
      sel_idx_q  <= pick_idx;
      sel_addr_q <= pick_addr;
    end
  end

  assign sel_done_o  = sel_done_q;
  assign sel_valid_o = sel_valid_q;
  assign sel_prio_o  = sel_prio_q;
  assign sel_idx_o   = sel_idx_q;
  assign sel_addr_o  = sel_addr_q;

  // R2
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_b)
    occupancy_o <= TW'(CAP));
  // R3
  enq_grow_chk: assert property (@(posedge clk) disable iff (!rst_b)
    (enq_ok_o && !do_issue) |=> (occupancy_o == TW'($past(occupancy_o) + 1'b1)));
  // R8
  issue_shrink_chk: assert property (@(posedge clk) disable iff (!rst_b)
    (do_issue && !enq_ok_o) |=> (occupancy_o == TW'($past(occupancy_o) - 1'b1)));
  // R7
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_b)
    (!enq_ok_o && !do_issue) |=> $stable(occupancy_o));
  // R12
  sel_lat_chk: assert property (@(posedge clk) disable iff (!rst_b)
    (sel_strobe_i && !issue_i) |=> sel_done_o);
  // R11
  issue_block_chk: assert property (@(posedge clk) disable iff (!rst_b)
    issue_i |=> !sel_done_o);
endmodule

// File: tb/prq_selector_bench.sv
module prq_selector_bench;
  import prq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NPRIO = 4;
  localparam int CAP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid_i = 0, enq_wr_i = 0;
  logic [ADDR_W-1:0] enq_addr_i = '0;
  logic [SIZE_W-1:0] enq_size_i = '0;
  logic [RANK_W-1:0] enq_rank_i = '0;
  logic [BANK_W-1:0] enq_bank_i = '0;
  logic [ROW_W-1:0]  enq_row_i = '0;
  logic [1:0] enq_prio_i = '0;
  logic enq_ok_o, enq_full_o, enq_covered_o;
  logic [NRANK-1:0] rank_idle_i = '0;
  logic sel_strobe_i = 0, issue_i = 0;
  logic sel_done_o, sel_valid_o;
  logic [1:0] sel_prio_o;
  logic [2:0] sel_idx_o;
  logic [ADDR_W-1:0] sel_addr_o;
  logic [4:0] occupancy_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  prq_selector #(.NPRIO(NPRIO), .CAP(CAP)) u_prq_selector (
    .clk(clk), .rst_n(rst_n),
    .enq_valid_i(enq_valid_i), .enq_wr_i(enq_wr_i), .enq_addr_i(enq_addr_i),
    .enq_size_i(enq_size_i), .enq_rank_i(enq_rank_i), .enq_bank_i(enq_bank_i),
    .enq_row_i(enq_row_i), .enq_prio_i(enq_prio_i),
    .enq_ok_o(enq_ok_o), .enq_full_o(enq_full_o), .enq_covered_o(enq_covered_o),
    .rank_idle_i(rank_idle_i), .sel_strobe_i(sel_strobe_i), .issue_i(issue_i),
    .sel_done_o(sel_done_o), .sel_valid_o(sel_valid_o), .sel_prio_o(sel_prio_o),
    .sel_idx_o(sel_idx_o), .sel_addr_o(sel_addr_o), .occupancy_o(occupancy_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model
  typedef struct { bit wr; int addr; int size; int rank; } ment_t;
  ment_t mq [NPRIO][$];
  bit h_v = 0;
  int h_p = 0, h_i = 0;

  // scoreboard of expected selection results
  bit    exp_f [$];
  int    exp_p [$], exp_i [$], exp_a [$];
  string exp_tag [$];

  function automatic int mtotal();
    int t = 0;
    for (int l = 0; l < NPRIO; l++) t += mq[l].size();
    return t;
  endfunction

  task automatic enq(input bit wr, input int addr, input int size, input int rank,
                     input int prio, input string req);
    bit cov = 0;
    bit full, ok;
    for (int l = 0; l < NPRIO; l++)
      foreach (mq[l][k])
        if (!wr && mq[l][k].wr && mq[l][k].addr <= addr &&
            addr + size <= mq[l][k].addr + mq[l][k].size) cov = 1;
    full = !cov && (mtotal() + 1 > CAP);
    ok   = !cov && !full;
    @(negedge clk);
    enq_valid_i = 1; enq_wr_i = wr; enq_addr_i = ADDR_W'(addr);
    enq_size_i = SIZE_W'(size); enq_rank_i = RANK_W'(rank); enq_prio_i = 2'(prio);
    #1;
    chk(enq_ok_o == ok, req, "enq_ok", enq_ok_o, ok);
    chk(enq_full_o == full, req, "enq_full", enq_full_o, full);
    chk(enq_covered_o == cov, req, "enq_covered", enq_covered_o, cov);
    @(posedge clk); #1;
    enq_valid_i = 0;
    if (ok) mq[prio].push_back('{wr, addr, size, rank});
  endtask

  task automatic sel(input logic [NRANK-1:0] idle, input string req);
    bit f = 0;
    int p = 0, i = 0;
    for (int l = NPRIO-1; l >= 0 && !f; l--)
      foreach (mq[l][k])
        if (!f && idle[mq[l][k].rank]) begin f = 1; p = l; i = k; end
    @(negedge clk);
    rank_idle_i = idle; sel_strobe_i = 1;
    exp_f.push_back(f); exp_p.push_back(p); exp_i.push_back(i);
    exp_a.push_back(f ? mq[p][i].addr : 0); exp_tag.push_back(req);
    h_v = f; h_p = p; h_i = i;
    @(posedge clk); #1;
    sel_strobe_i = 0;
  endtask

  task automatic iss(input bit with_strobe);
    @(negedge clk);
    issue_i = 1; sel_strobe_i = with_strobe; rank_idle_i = '1;
    @(posedge clk); #1;
    issue_i = 0; sel_strobe_i = 0;
    if (h_v) begin mq[h_p].delete(h_i); h_v = 0; end
  endtask

  task automatic chk_occ(input string req);
    @(negedge clk);
    chk(occupancy_o == 5'(mtotal()), req, "occupancy", occupancy_o, mtotal());
  endtask

  // monitor: compares each produced result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && sel_done_o) begin
      if (exp_f.size() == 0) begin
        chk(0, "R11", "unexpected sel_done", 1, 0);
      end else begin
        automatic bit    f = exp_f.pop_front();
        automatic int    p = exp_p.pop_front();
        automatic int    i = exp_i.pop_front();
        automatic int    a = exp_a.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(sel_valid_o == f, t, "sel_valid (R12)", sel_valid_o, f);
        if (f) begin
          chk(sel_prio_o == 2'(p), t, "sel_prio", sel_prio_o, p);
          chk(sel_idx_o == 3'(i), t, "sel_idx", sel_idx_o, i);
          chk(sel_addr_o == ADDR_W'(a), t, "sel_addr", sel_addr_o, a);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(occupancy_o == 0, "R1", "occupancy", occupancy_o, 0);
    chk(sel_valid_o == 0, "R1", "sel_valid", sel_valid_o, 0);
    chk(sel_done_o == 0, "R1", "sel_done", sel_done_o, 0);
    // R7 empty queues
    sel(4'b1111, "R7");
    // R3 fill levels
    enq(0, 'h100, 8, 0, 0, "R3");
    enq(0, 'h200, 8, 1, 2, "R3");
    enq(0, 'h300, 8, 2, 2, "R3");
    enq(0, 'h400, 8, 3, 1, "R3");
    enq(1, 'h1000, 64, 0, 1, "R3");
    chk_occ("R3");
    // R4 highest level first
    sel(4'b1111, "R4");
    // R5 skip busy rank in a level
    sel(4'b1101, "R5");
    sel(4'b0001, "R5");
    // R6 single entry with busy rank
    enq(0, 'h500, 8, 3, 3, "R6");
    sel(4'b0111, "R6");
    // R2 pool full
    enq(0, 'h600, 8, 0, 0, "R2");
    chk_occ("R2");
    // R10 covered reads, partial overlap, exact fit
    enq(0, 'h1010, 16, 1, 0, "R10");
    enq(0, 'h1030, 32, 1, 0, "R10");
    enq(0, 'h1000, 64, 1, 0, "R10");
    chk_occ("R10");
    // R8 select twice without issue, then issue
    sel(4'b1111, "R8");
    sel(4'b1111, "R8");
    chk_occ("R8");
    iss(0);
    chk_occ("R8");
    sel(4'b0100, "R9");
    iss(0);
    enq(0, 'h700, 8, 1, 0, "R3");
    enq(0, 'h800, 8, 2, 0, "R3");
    sel(4'b0010, "R9");
    iss(0);
    sel(4'b0010, "R9");
    iss(0);
    // R9 compaction: entry moved from index 2 to 1
    sel(4'b0100, "R9");
    sel(4'b0001, "R5");
    chk_occ("R9");
    // R7 nothing idle, nonempty
    sel(4'b0000, "R7");
    chk_occ("R7");
    // R11 issue with no held selection
    iss(0);
    chk_occ("R11");
    // R11 strobe during issue is ignored
    sel(4'b0001, "R11");
    iss(1);
    chk_occ("R11");
    @(negedge clk);
    chk(sel_done_o == 0, "R11", "sel_done after blocked strobe", sel_done_o, 0);
    repeat (3) @(negedge clk);
    chk(exp_f.size() == 0, "R12", "pending results", exp_f.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule